// File: doc/BRIEF.md
# FIFO Threshold Interrupt Unit

This unit sits between a host register interface and the bit-level engine of a serial controller. It holds a transmit FIFO that the host fills and the engine drains, and a receive FIFO that the engine fills and the host drains. Both FIFOs report their fill counts. Each has a programmable watermark, and five event sources feed a status word, a mask and one combined interrupt line.

The host reaches every register through a single select/strobe port. Data writes and reads go to the FIFOs. The two watermarks and the mask can be written. Both fill counts, the unmasked status and the masked status can be read. A write to the unmasked-status address clears the error flags. The engine side uses plain strobes: it pops the transmit head when `eng_tx_valid` is high and pushes received frames with a single strobe.

A two-state controller tracks the enable input. In `ST_OFF` both FIFOs are held empty and the error flags are held clear. In `ST_ON` traffic is accepted. The transition `ST_OFF -> ST_ON` is taken on an edge where `ctl_en` is 1. The transition `ST_ON -> ST_OFF` is taken on an edge where `ctl_en` is 0. Reset enters `ST_OFF`.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset both fill counts read 0, both watermarks read 0, the mask reads 0, the unmasked status reads 0x01 and `irq_out` is 0.
- R2: Words written to select 0 (data) leave on `eng_tx_data` in write order. `eng_tx_valid` is 1 whenever the transmit count (select 4) is non-zero.
- R3: Frames pushed by the engine are returned in arrival order by reads of select 0. Each read removes one entry from the receive count (select 5).
- R4: A write to a watermark (select 1 transmit, select 2 receive) that is larger than DEPTH-1 leaves the stored value unchanged.
- R5: Status bit 0 (transmit low) is 1 exactly when the transmit count is less than or equal to the transmit watermark.
- R6: Status bit 4 (receive high) is 1 exactly when the receive count is strictly greater than the receive watermark. A watermark of 0 therefore fires on a single entry.
- R7: A data write while the transmit FIFO is full is dropped and sets sticky status bit 1.
- R8: A data read while the receive FIFO is empty returns 0, removes nothing and sets sticky status bit 2.
- R9: An engine push while the receive FIFO is full drops that frame, leaves the stored frames intact and sets sticky status bit 3.
- R10: The masked status (select 7) is the unmasked status (select 6) ANDed with the mask (select 3). With the mask at 0 the unmasked status keeps updating. Status bit 5 always reads 0.
- R11: `irq_out` equals the OR of the masked status bits, delayed by one clock.
- R12: A write to select 6 clears status bits 1 to 3 on that edge. The clear wins over a new event on the same edge.
- R13: Once `ctl_en` is sampled low the unit enters `ST_OFF`. On the next edge both counts become 0 and bits 1 to 3 clear. Data writes and pushes made while off are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_en | input | 1 | Controller enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at select 0) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the select |
| irq_out | output | 1 | Combined registered interrupt |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | DW | Transmit head word |
| eng_tx_valid | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | DW | Received frame |

## Verification
The watermark comparisons are swept through a vector table that pairs watermark writes with fill counts. The table covers the limit value DEPTH-1, an out-of-range write that must not stick, a watermark of 0 and a full FIFO, so the at-or-below and above-but-not-full cases are told apart. Full and empty boundaries are driven in both directions to show that a dropped word or frame neither corrupts the order nor moves the counts. Mask changes are paired with a known sticky flag, so the one-clock lag of `irq_out` is separated from the status path itself. A disable with data queued and flags set shows the flush, and shows that writes made while off are discarded.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_TXWM  = 3'd1,
        SEL_RXWM  = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_TXCNT = 3'd4,
        SEL_RXCNT = 3'd5,
        SEL_RAW   = 3'd6,
        SEL_MSKD  = 3'd7
    } sel_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } ctl_state_e;

    localparam int NSRC    = 6;
    localparam int B_TXLOW = 0;
    localparam int B_TXOVF = 1;
    localparam int B_RXUDF = 2;
    localparam int B_RXOVF = 3;
    localparam int B_RXHI  = 4;
    localparam int B_SPARE = 5;

endpackage

// File: rtl/fiu_fifo.sv
module fiu_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp, wp_nx, rp_nx;
    logic [LW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full  = (cnt == LW'(DEPTH));
    assign empty = (cnt == '0);
    assign do_wr = push & ~full;
    assign do_rd = pop & ~empty;

    generate
        if (POW2) begin : g_natural_wrap
            assign wp_nx = wp + 1'b1;
            assign rp_nx = rp + 1'b1;
        end else begin : g_compare_wrap
            assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp_nx;
            if (do_rd) rp <= rp_nx;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = empty ? '0 : mem[rp];
    assign level = cnt;

endmodule

// File: rtl/fiu_thresh.sv
module fiu_thresh #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [LW-1:0] value
);

    localparam logic [DW-1:0] LIMIT = DW'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr && (wdata <= LIMIT)) begin
            value <= wdata[LW-1:0];
        end
    end

endmodule

// File: rtl/fiu_irq.sv
module fiu_irq
    import fiu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            clr,
    input  logic            ev_txovf,
    input  logic            ev_rxudf,
    input  logic            ev_rxovf,
    input  logic            lvl_txlow,
    input  logic            lvl_rxhi,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] mask_wdata,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] masked,
    output logic [NSRC-1:0] mask,
    output logic            irq
);

    localparam int NSTICKY = 3;

    logic [NSTICKY-1:0] ev;
    logic [NSTICKY-1:0] flag;

    assign ev = {ev_rxovf, ev_rxudf, ev_txovf};

    generate
        for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag[i] <= 1'b0;
                end else if (flush || clr) begin
                    flag[i] <= 1'b0;
                end else if (ev[i]) begin
                    flag[i] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= mask_wdata;
        end
    end

    always_comb begin
        raw          = '0;
        raw[B_TXLOW] = lvl_txlow;
        raw[B_TXOVF] = flag[0];
        raw[B_RXUDF] = flag[1];
        raw[B_RXOVF] = flag[2];
        raw[B_RXHI]  = lvl_rxhi;
        raw[B_SPARE] = 1'b0;
    end

    assign masked = raw & mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |masked;
        end
    end

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
    import fiu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_out,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_valid,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data
);

    localparam int LW = $clog2(DEPTH + 1);

    ctl_state_e state, state_nx;
    logic       run, flush;

    logic [LW-1:0]   tx_lvl, rx_lvl, tx_thr, rx_thr;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]   rx_head;
    logic [NSRC-1:0] raw_st, msk_st, mask_q;
    logic            hit_data, tx_push, rx_pop, rx_push, tx_take;
    logic            ev_txovf, ev_rxudf, ev_rxovf, clr_flags;
    logic            rx_push_full;

    // controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // next state and state outputs
    always_comb begin
        state_nx = state;
        run      = 1'b0;
        unique case (state)
            ST_OFF: begin
                run = 1'b0;
                if (ctl_en) state_nx = ST_ON;
            end
            ST_ON: begin
                run = 1'b1;
                if (!ctl_en) state_nx = ST_OFF;
            end
        endcase
    end

    assign flush = ~run;

    // register decode
    assign hit_data     = (bus_addr == SEL_DATA);
    assign tx_push      = run & bus_wr & hit_data;
    assign rx_pop       = run & bus_rd & hit_data;
    assign rx_push      = run & eng_rx_push;
    assign tx_take      = run & eng_tx_pop;
    assign ev_txovf     = tx_push & tx_full;
    assign ev_rxudf     = rx_pop & rx_empty;
    assign ev_rxovf     = rx_push & rx_full;
    assign rx_push_full = ev_rxovf;
    assign clr_flags    = bus_wr & (bus_addr == SEL_RAW);

    fiu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (tx_push),
        .push_data (bus_wdata),
        .pop       (tx_take),
        .head      (eng_tx_data),
        .level     (tx_lvl),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    fiu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .level     (rx_lvl),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    fiu_thresh #(.DW(DW), .DEPTH(DEPTH)) u_txwm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && (bus_addr == SEL_TXWM)),
        .wdata (bus_wdata),
        .value (tx_thr)
    );

    fiu_thresh #(.DW(DW), .DEPTH(DEPTH)) u_rxwm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr && (bus_addr == SEL_RXWM)),
        .wdata (bus_wdata),
        .value (rx_thr)
    );

    fiu_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .clr        (clr_flags),
        .ev_txovf   (ev_txovf),
        .ev_rxudf   (ev_rxudf),
        .ev_rxovf   (ev_rxovf),
        .lvl_txlow  (tx_lvl <= tx_thr),
        .lvl_rxhi   (rx_lvl > rx_thr),
        .mask_wr    (bus_wr && (bus_addr == SEL_MASK)),
        .mask_wdata (bus_wdata[NSRC-1:0]),
        .raw        (raw_st),
        .masked     (msk_st),
        .mask       (mask_q),
        .irq        (irq_out)
    );

    assign eng_tx_valid = ~tx_empty;

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            SEL_DATA:  bus_rdata = rx_head;
            SEL_TXWM:  bus_rdata = DW'(tx_thr);
            SEL_RXWM:  bus_rdata = DW'(rx_thr);
            SEL_MASK:  bus_rdata = DW'(mask_q);
            SEL_TXCNT: bus_rdata = DW'(tx_lvl);
            SEL_RXCNT: bus_rdata = DW'(rx_lvl);
            SEL_RAW:   bus_rdata = DW'(raw_st);
            SEL_MSKD:  bus_rdata = DW'(msk_st);
        endcase
    end

endmodule

// File: rtl/fiu_chk.sv
module fiu_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4,
    parameter int NS    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          clr,
    input logic          rx_push_full,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl,
    input logic [LW-1:0] tx_thr,
    input logic [LW-1:0] rx_thr,
    input logic [NS-1:0] raw,
    input logic [NS-1:0] masked,
    input logic [NS-1:0] mask,
    input logic          irq
);

    p_lvl_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

    p_thr_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_thr <= LW'(DEPTH - 1)) && (rx_thr <= LW'(DEPTH - 1)));

    p_txovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[1] && run && !clr) |=> raw[1]);

    p_rxovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_full && !clr) |=> raw[3]);

    p_spare_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !raw[5]);

    p_irq_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|masked)));

    p_mask_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && $past(mask) == '0) |-> !irq);

    p_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (tx_lvl == '0 && rx_lvl == '0 && raw[3:1] == 3'b000));

endmodule

bind fifo_irq_unit fiu_chk #(.DEPTH(DEPTH), .LW(LW), .NS(fiu_pkg::NSRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .clr          (clr_flags),
    .rx_push_full (rx_push_full),
    .tx_lvl       (tx_lvl),
    .rx_lvl       (rx_lvl),
    .tx_thr       (tx_thr),
    .rx_thr       (rx_thr),
    .raw          (raw_st),
    .masked       (msk_st),
    .mask         (mask_q),
    .irq          (irq_out)
);

// File: tb/sim_fifo_irq_unit.sv
`timescale 1ns/1ps
module sim_fifo_irq_unit;

    localparam int DW    = 16;
    localparam int DEPTH = 8;

    localparam logic [2:0] A_DATA = 3'd0, A_TXWM = 3'd1, A_RXWM = 3'd2, A_MASK = 3'd3,
                           A_TXCNT = 3'd4, A_RXCNT = 3'd5, A_RAW = 3'd6, A_MSKD = 3'd7;

    // {watermark write, words written, expected watermark, expected bit0}
    localparam logic [31:0] TBL [7] = '{
        {8'd3, 8'd3, 8'd3, 8'd1},
        {8'd3, 8'd4, 8'd3, 8'd0},
        {8'd9, 8'd2, 8'd3, 8'd1},
        {8'd7, 8'd8, 8'd7, 8'd0},
        {8'd7, 8'd7, 8'd7, 8'd1},
        {8'd0, 8'd0, 8'd0, 8'd1},
        {8'd8, 8'd1, 8'd0, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n, ctl_en, bus_wr, bus_rd, eng_tx_pop, eng_rx_push;
    logic [2:0]    bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, eng_tx_data, eng_rx_data;
    logic          irq_out, eng_tx_valid;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [DW-1:0] d);
        eng_rx_data = d; eng_rx_push = 1'b1;
        @(posedge clk); @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic pop_tx(output logic [DW-1:0] d);
        d = eng_tx_data; eng_tx_pop = 1'b1;
        @(posedge clk); @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic flush_unit();
        ctl_en = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ctl_en = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        rst_n = 1'b0; ctl_en = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
        bus_wdata = '0; eng_tx_pop = 1'b0; eng_rx_push = 1'b0; eng_rx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", irq_out, 0);
        rd_reg(A_TXCNT, d); check("R1 txcnt", d, 0);
        rd_reg(A_RXCNT, d); check("R1 rxcnt", d, 0);
        rd_reg(A_TXWM, d);  check("R1 txwm", d, 0);
        rd_reg(A_RXWM, d);  check("R1 rxwm", d, 0);
        rd_reg(A_MASK, d);  check("R1 mask", d, 0);
        rd_reg(A_RAW, d);   check("R1 raw", d, 16'h0001);

        // table: watermark limit (R4) and transmit-low compare (R5)
        for (int i = 0; i < 7; i++) begin
            flush_unit();
            wr_reg(A_TXWM, DW'(TBL[i][31:24]));
            for (int j = 0; j < int'(TBL[i][23:16]); j++) wr_reg(A_DATA, DW'(16'hA000 + j));
            rd_reg(A_TXCNT, d); check("R2 txcnt", d, DW'(TBL[i][23:16]));
            rd_reg(A_RAW, d);   check("R5 txlow", d[0], TBL[i][0]);
            rd_reg(A_TXWM, d);  check("R4 txwm", d, DW'(TBL[i][15:8]));
        end

        // R4 receive watermark limit
        wr_reg(A_RXWM, 16'd7);  rd_reg(A_RXWM, d); check("R4 rxwm max", d, 7);
        wr_reg(A_RXWM, 16'd8);  rd_reg(A_RXWM, d); check("R4 rxwm over", d, 7);
        wr_reg(A_RXWM, 16'd0);

        // R2 transmit order
        flush_unit();
        wr_reg(A_DATA, 16'h1111); wr_reg(A_DATA, 16'h2222); wr_reg(A_DATA, 16'h3333);
        check("R2 valid", eng_tx_valid, 1);
        pop_tx(d); check("R2 word0", d, 16'h1111);
        pop_tx(d); check("R2 word1", d, 16'h2222);
        pop_tx(d); check("R2 word2", d, 16'h3333);
        check("R2 valid low", eng_tx_valid, 0);

        // R3 / R6 receive order and high watermark
        flush_unit();
        push_rx(16'h0055);
        rd_reg(A_RAW, d); check("R6 wm0 one entry", d[4], 1);
        wr_reg(A_RXWM, 16'd1);
        rd_reg(A_RAW, d); check("R6 equal not above", d[4], 0);
        push_rx(16'h0066);
        rd_reg(A_RAW, d); check("R6 above", d[4], 1);
        rd_reg(A_DATA, d); check("R3 frame0", d, 16'h0055);
        rd_reg(A_RXCNT, d); check("R3 rxcnt", d, 1);
        rd_reg(A_DATA, d); check("R3 frame1", d, 16'h0066);

        // R8 underflow, R12 clear
        rd_reg(A_DATA, d); check("R8 empty read", d, 0);
        rd_reg(A_RXCNT, d); check("R8 rxcnt", d, 0);
        rd_reg(A_RAW, d); check("R8 flag", d[2], 1);
        wr_reg(A_RAW, 16'h0000);
        rd_reg(A_RAW, d); check("R12 cleared", d[2], 0);

        // R7 transmit overflow
        flush_unit();
        for (int j = 0; j < DEPTH; j++) wr_reg(A_DATA, DW'(16'hB000 + j));
        rd_reg(A_RAW, d); check("R7 no flag yet", d[1], 0);
        wr_reg(A_DATA, 16'hEEEE);
        rd_reg(A_RAW, d); check("R7 flag", d[1], 1);
        rd_reg(A_TXCNT, d); check("R7 txcnt", d, DEPTH);
        for (int j = 0; j < DEPTH; j++) pop_tx(d);
        check("R7 last kept", d, DW'(16'hB000 + DEPTH - 1));
        check("R7 dropped", eng_tx_valid, 0);

        // R9 receive overflow
        wr_reg(A_RXWM, 16'd0);
        for (int j = 0; j < DEPTH; j++) push_rx(DW'(16'h0010 + j));
        push_rx(16'h0099);
        rd_reg(A_RAW, d); check("R9 flag", d[3], 1);
        rd_reg(A_RXCNT, d); check("R9 rxcnt", d, DEPTH);
        for (int j = 0; j < DEPTH; j++) begin
            rd_reg(A_DATA, d); check("R9 frame", d, DW'(16'h0010 + j));
        end

        // R10 / R11 mask and registered output
        rd_reg(A_RAW, d); check("R10 raw with mask 0", d, 16'h000B);
        check("R10 irq blocked", irq_out, 0);
        wr_reg(A_MASK, 16'h0002);
        check("R11 lag", irq_out, 0);
        @(posedge clk); @(negedge clk);
        check("R11 irq set", irq_out, 1);
        rd_reg(A_MSKD, d); check("R10 masked", d, 16'h0002);
        wr_reg(A_MASK, 16'h0000);
        check("R11 still high", irq_out, 1);
        @(posedge clk); @(negedge clk);
        check("R11 irq clear", irq_out, 0);

        // R13 disable flush
        wr_reg(A_DATA, 16'h4444); push_rx(16'h0077);
        rd_reg(A_RAW, d); check("R13 preset", d[3:1], 3'b101);
        ctl_en = 1'b0;
        @(posedge clk); @(negedge clk);
        wr_reg(A_DATA, 16'h5555);
        push_rx(16'h0088);
        rd_reg(A_TXCNT, d); check("R13 txcnt", d, 0);
        rd_reg(A_RXCNT, d); check("R13 rxcnt", d, 0);
        rd_reg(A_RAW, d);   check("R13 raw", d, 16'h0001);
        ctl_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_reg(A_TXCNT, d); check("R13 off write ignored", d, 0);
        check("R13 valid", eng_tx_valid, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule